// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the effective address of a memory operand of the general form base plus scaled index plus displacement. The register file has already read the base and index values. The block takes those values together with flags that say whether a base and an index are present, the 3-bit code of the index register, a 2-bit scale code and a displacement with its size code. It produces a 32-bit address and a flag that marks an illegal encoding. It has no memory port of its own, and it does not touch any condition code. The same result can therefore feed a load/store unit as an address, or go directly to a destination register for an address-computation arithmetic operation.

The path is combinational from the inputs to a single register stage. That register captures the result on an input strobe, so the outputs are valid one cycle later. The register stage can be removed with a parameter. The outputs keep their last value until the next strobe. The sum wraps modulo 2^32.

Top module: `eff_addr_gen`

## Requirements
- R1: One cycle after a strobe, `addr_out` equals (base + index × 2^scale_code + extended displacement) modulo 2^32, using the operand values present at the strobe.
- R2: Scale code 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8 respectively.
- R3: Displacement size code 0 means no displacement (adds zero). Code 1 sign-extends bits [7:0], code 2 sign-extends bits [15:0], and code 3 uses all 32 bits. For codes 1 and 2, the bits of `disp_val` above the selected width have no effect on the address.
- R4: With `base_en` low, the base contributes zero whatever `base_val` holds.
- R5: With `index_en` low, the index contributes zero whatever `index_val` and `scale_code` hold.
- R6: `illegal_out` is 1 one cycle after a strobe exactly when `index_en` is high and `index_sel` equals 4 (the stack pointer code). Otherwise it is 0. The address is still computed in the usual way.
- R7: `out_valid` is high in the cycle after a strobe and low in the cycle after a cycle with no strobe.
- R8: With no strobe, `addr_out` and `illegal_out` keep their previous values.
- R9: Synchronous active-high reset clears `out_valid`, `addr_out` and `illegal_out` to 0.
- R10: Reference points: index 0xF000 with scale ×2 and displacement 0x80 and no base gives 0x1E080. Base 0xF000 with index 0x100 and scale ×4 gives 0xF400. Base 0xF000 with displacement 8 and no index gives 0xF008.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture an address computation |
| base_en | input | 1 | Base register present |
| index_en | input | 1 | Index register present |
| index_sel | input | 3 | Index register code (4 = stack pointer, illegal) |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| disp_val | input | 32 | Displacement, low-aligned |
| disp_size | input | 2 | 0 none, 1 byte, 2 halfword, 3 word |
| out_valid | output | 1 | Result valid |
| addr_out | output | 32 | Effective address |
| illegal_out | output | 1 | Stack pointer used as index |

## Verification
The bench builds the block with its default parameters: a 32-bit address, stack pointer code 4, and the output register present. With these settings the one-cycle latency, the hold behaviour between strobes and the reset values can all be observed. Because the width is 32, operands near 2^32 make the wrap-around of the three-way sum reachable. The bench also feeds displacements whose upper bits are garbage, so it can confirm that the sign extension for byte and halfword sizes looks only at the selected width.

// File: rtl/eff_addr_pkg.sv
package eff_addr_pkg;
  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_BYTE = 2'd1,
    DSZ_HALF = 2'd2,
    DSZ_WORD = 2'd3
  } disp_size_e;

  localparam int SCALE_W = 2;
  localparam int RSEL_W  = 3;
endpackage

// File: rtl/eff_disp_ext.sv
module eff_disp_ext #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] disp_raw,
  input  logic [1:0]    size_code,
  output logic [AW-1:0] disp_ext
);
  import eff_addr_pkg::*;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [AW-1:0] ext_byte;
  logic [AW-1:0] ext_half;

  assign ext_byte = {{(AW-BYTE_W){disp_raw[BYTE_W-1]}}, disp_raw[BYTE_W-1:0]};
  assign ext_half = {{(AW-HALF_W){disp_raw[HALF_W-1]}}, disp_raw[HALF_W-1:0]};

  always_comb begin
    unique case (disp_size_e'(size_code))
      DSZ_NONE: disp_ext = '0;
      DSZ_BYTE: disp_ext = ext_byte;
      DSZ_HALF: disp_ext = ext_half;
      default:  disp_ext = disp_raw;
    endcase
  end
endmodule

// File: rtl/eff_index_scale.sv
module eff_index_scale #(
  parameter int AW      = 32,
  parameter int SCALE_W = 2
) (
  input  logic               idx_en,
  input  logic [AW-1:0]      idx_val,
  input  logic [SCALE_W-1:0] shamt,
  output logic [AW-1:0]      idx_scaled
);
  localparam int NSTEP = 1 << SCALE_W;

  logic [AW-1:0] gated;
  logic [AW-1:0] shifted [NSTEP];

  assign gated = idx_en ? idx_val : '0;

  for (genvar s = 0; s < NSTEP; s++) begin : g_shift
    assign shifted[s] = gated << s;
  end

  assign idx_scaled = shifted[shamt];
endmodule

// File: rtl/eff_sum3.sv
module eff_sum3 #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] op_a,
  input  logic [AW-1:0] op_b,
  input  logic [AW-1:0] op_c,
  output logic [AW-1:0] sum
);
  assign sum = op_a + op_b + op_c;
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int AW      = 32,
  parameter int SP_CODE = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          base_en,
  input  logic          index_en,
  input  logic [2:0]    index_sel,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    scale_code,
  input  logic [AW-1:0] disp_val,
  input  logic [1:0]    disp_size,
  output logic          out_valid,
  output logic [AW-1:0] addr_out,
  output logic          illegal_out
);
  import eff_addr_pkg::*;

  logic [AW-1:0] base_term;
  logic [AW-1:0] index_term;
  logic [AW-1:0] disp_term;
  logic [AW-1:0] addr_comb;
  logic          bad_index;

  assign base_term = base_en ? base_val : '0;
  assign bad_index = index_en && (index_sel == RSEL_W'(SP_CODE));

  eff_index_scale #(.AW(AW), .SCALE_W(SCALE_W)) u_scale (
    .idx_en     (index_en),
    .idx_val    (index_val),
    .shamt      (scale_code),
    .idx_scaled (index_term)
  );

  eff_disp_ext #(.AW(AW)) u_disp (
    .disp_raw  (disp_val),
    .size_code (disp_size),
    .disp_ext  (disp_term)
  );

  eff_sum3 #(.AW(AW)) u_sum (
    .op_a (base_term),
    .op_b (index_term),
    .op_c (disp_term),
    .sum  (addr_comb)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid   <= 1'b0;
        addr_out    <= '0;
        illegal_out <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          addr_out    <= addr_comb;
          illegal_out <= bad_index;
        end
      end
    end
  end else begin : g_comb
    assign out_valid   = in_valid;
    assign addr_out    = addr_comb;
    assign illegal_out = bad_index;
  end
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk #(
  parameter int AW      = 32,
  parameter int SP_CODE = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          base_en,
  input logic          index_en,
  input logic [2:0]    index_sel,
  input logic [AW-1:0] base_val,
  input logic [AW-1:0] index_val,
  input logic [1:0]    scale_code,
  input logic [AW-1:0] disp_val,
  input logic [1:0]    disp_size,
  input logic          out_valid,
  input logic [AW-1:0] addr_out,
  input logic          illegal_out
);
  if (OUT_REG) begin : g_props
    assert_strobe_latency_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    assert_idle_latency_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    assert_sp_index_flag_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && index_en && index_sel == 3'(SP_CODE)) |=> illegal_out);
    assert_legal_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !(index_en && index_sel == 3'(SP_CODE))) |=> !illegal_out);
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(addr_out) && $stable(illegal_out)));
    assert_byte_disp_only_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !base_en && !index_en && disp_size == 2'd1) |=>
      addr_out == {{(AW-8){$past(disp_val[7])}}, $past(disp_val[7:0])});
    assert_base_passthru_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && base_en && !index_en && disp_size == 2'd0) |=>
      addr_out == $past(base_val));
    assert_index_passthru_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !base_en && index_en && scale_code == 2'd0 && disp_size == 2'd0) |=>
      addr_out == $past(index_val));
    assert_reset_clears_R9: assert property (@(posedge clk)
      rst |=> (!out_valid && addr_out == '0 && !illegal_out));
  end
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.AW(AW), .SP_CODE(SP_CODE), .OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .base_en(base_en), .index_en(index_en),
  .index_sel(index_sel), .base_val(base_val), .index_val(index_val),
  .scale_code(scale_code), .disp_val(disp_val), .disp_size(disp_size),
  .out_valid(out_valid), .addr_out(addr_out), .illegal_out(illegal_out)
);

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        base_en = 1'b0;
  logic        index_en = 1'b0;
  logic [2:0]  index_sel = '0;
  logic [31:0] base_val = '0;
  logic [31:0] index_val = '0;
  logic [1:0]  scale_code = '0;
  logic [31:0] disp_val = '0;
  logic [1:0]  disp_size = '0;
  logic        out_valid;
  logic [31:0] addr_out;
  logic        illegal_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  string       drv_tag = "R1";
  string       exp_tag = "R9";
  logic        exp_valid = 0;
  logic [31:0] exp_addr = 0;
  logic        exp_ill = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eff_addr_gen dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base_en(base_en), .index_en(index_en),
    .index_sel(index_sel), .base_val(base_val), .index_val(index_val),
    .scale_code(scale_code), .disp_val(disp_val), .disp_size(disp_size),
    .out_valid(out_valid), .addr_out(addr_out), .illegal_out(illegal_out)
  );

  function automatic logic [31:0] model_addr();
    longint unsigned total;
    longint unsigned factor;
    longint signed d;
    case (scale_code)
      2'd0: factor = 1;
      2'd1: factor = 2;
      2'd2: factor = 4;
      default: factor = 8;
    endcase
    case (disp_size)
      2'd0: d = 0;
      2'd1: d = longint'($signed(disp_val[7:0]));
      2'd2: d = longint'($signed(disp_val[15:0]));
      default: d = longint'($signed(disp_val));
    endcase
    total = 0;
    if (base_en) total = total + longint'(base_val);
    if (index_en) total = total + longint'(index_val) * factor;
    total = total + longint'(unsigned'(d));
    return total[31:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_valid = 0; exp_addr = 0; exp_ill = 0; exp_tag = "R9";
    end else if (in_valid) begin
      exp_valid = 1;
      exp_addr  = model_addr();
      exp_ill   = index_en && (index_sel == 3'd4);
      exp_tag   = drv_tag;
    end else begin
      exp_valid = 0;
      exp_tag   = "R8";
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual 0x%08h expected 0x%08h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check((exp_tag == "R9") ? "R9" : "R7", {31'd0, out_valid}, {31'd0, exp_valid});
      check((exp_tag == "R9") ? "R9" : "R6", {31'd0, illegal_out}, {31'd0, exp_ill});
      check(exp_tag, addr_out, exp_addr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic issue(string tag, bit be, bit ie, logic [2:0] isel, logic [31:0] bv,
                       logic [31:0] iv, logic [1:0] sc, logic [31:0] dv, logic [1:0] ds);
    @(negedge clk);
    drv_tag = tag; in_valid = 1; base_en = be; index_en = ie; index_sel = isel;
    base_val = bv; index_val = iv; scale_code = sc; disp_val = dv; disp_size = ds;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0;
      base_val = $urandom; index_val = $urandom; disp_val = $urandom;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk);
    rst = 0;
    // R10 reference points
    issue("R10", 0, 1, 3'd2, 32'hDEAD_BEEF, 32'h0000_F000, 2'd1, 32'h0000_0080, 2'd3);
    issue("R10", 1, 1, 3'd1, 32'h0000_F000, 32'h0000_0100, 2'd2, 32'h0, 2'd0);
    issue("R10", 1, 0, 3'd0, 32'h0000_F000, 32'h1234_5678, 2'd3, 32'hFFFF_FF08, 2'd1);
    idle(2);
    // R2 scale sweep
    for (int s = 0; s < 4; s++)
      issue("R2", 1, 1, 3'd6, 32'h0000_1000, 32'h0000_0011, 2'(s), 32'h0, 2'd0);
    // R3 displacement sizes with garbage upper bits, negative and positive
    issue("R3", 1, 0, 3'd0, 32'h0000_1000, 32'h0, 2'd0, 32'hABCD_EF80, 2'd1);
    issue("R3", 1, 0, 3'd0, 32'h0000_1000, 32'h0, 2'd0, 32'h5555_557F, 2'd1);
    issue("R3", 1, 0, 3'd0, 32'h0000_1000, 32'h0, 2'd0, 32'h1234_8000, 2'd2);
    issue("R3", 1, 0, 3'd0, 32'h0000_1000, 32'h0, 2'd0, 32'hFFFF_7FFF, 2'd2);
    issue("R3", 1, 0, 3'd0, 32'h0000_1000, 32'h0, 2'd0, 32'hFFFF_FFFF, 2'd0);
    issue("R3", 1, 0, 3'd0, 32'h0000_1000, 32'h0, 2'd0, 32'h8000_0000, 2'd3);
    // R4 base absent, R5 index absent
    issue("R4", 0, 1, 3'd3, 32'hFFFF_FFFF, 32'h0000_0040, 2'd3, 32'h4, 2'd1);
    issue("R5", 1, 0, 3'd4, 32'h0000_0300, 32'hFFFF_FFFF, 2'd3, 32'h0, 2'd0);
    // R6 stack pointer as index, then legal neighbours
    issue("R6", 1, 1, 3'd4, 32'h0000_0010, 32'h0000_0002, 2'd1, 32'h1, 2'd1);
    issue("R6", 1, 1, 3'd5, 32'h0000_0010, 32'h0000_0002, 2'd1, 32'h1, 2'd1);
    issue("R6", 1, 0, 3'd4, 32'h0000_0010, 32'h0000_0002, 2'd1, 32'h1, 2'd1);
    idle(3);
    // R1 wrap-around
    issue("R1", 1, 1, 3'd0, 32'hFFFF_FFF0, 32'h2000_0000, 2'd3, 32'h0000_0020, 2'd3);
    idle(1);
    // R1 random mix with gaps
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else issue("R1", 1'($urandom), 1'($urandom), 3'($urandom), $urandom, $urandom,
                 2'($urandom), $urandom, 2'($urandom));
    end
    idle(2);
    // R9 reset mid-stream
    issue("R9", 1, 1, 3'd1, 32'h1, 32'h2, 2'd0, 32'h3, 2'd3);
    @(negedge clk);
    rst = 1; in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule